// File: doc/BRIEF.md
# Calibration Trim DAC Serial Loader

This block programs a bank of 8-bit trim DACs that share one serial clock line and one serial data line. A host gives a DAC address, a new code and a one-cycle start pulse. The block shifts out a 12-bit frame: the address bits first, then the code bits, each group most significant bit first. After the last bit it pulses a shared load strobe that commits the code into the addressed DAC. A serial memory that shares the same wires has its chip select and write-protect release driven inactive by this block at all times, so that memory never treats DAC traffic as its own.

The block keeps a copy of the last code sent to each DAC. If a request asks for the code a DAC already holds, no frame is sent. The host can read any stored copy through a separate readback address. When reset is released, the block walks every DAC in ascending address order and loads each one with mid-scale. It reports busy for the whole of that sweep.

The serial rate is set by a parameter that gives the number of system clock cycles in each half of a serial clock period. The same count sets the width of the load pulse.

Top module: `caldac_loader`

## Requirements
- R1: Each frame holds exactly 12 bits. The 4-bit DAC address comes first, then the 8-bit code, and each field goes most significant bit first. Bit k of the frame (k = 0 first) is the value on `sdata_o` at the k-th rising edge of `sclk_o`.
- R2: For each bit, `sdata_o` changes only while `sclk_o` is low. `sclk_o` then rises and stays high for HALF_CYC clock cycles with `sdata_o` held steady. It is low for HALF_CYC cycles before each rise.
- R3: `load_o` stays low while bits are shifted. After the last falling edge of `sclk_o` it goes high for exactly HALF_CYC cycles with `sclk_o` low, once per frame.
- R4: `eeprom_cs_o` and `eeprom_wp_o` are 0 at all times, both in reset and during transfers.
- R5: When no transfer is running and a start arrives whose code equals the stored copy for that address, no frame is sent, `busy_o` stays low and the stored copy is unchanged.
- R6: After reset is released, the block sends one frame per DAC, for addresses 0 up to NUM_CH-1 in that order, each with code 0x80. `busy_o` is high from reset until the load pulse of the last of these frames ends.
- R7: `rb_data_o` returns the code held for `rb_addr_i`. Every copy is 0x80 after reset, and a copy takes the new code when a request for it is accepted.
- R8: `busy_o` rises on the clock edge that samples an accepted start. It falls on the same edge on which `load_o` falls. A start that arrives while `busy_o` is high is ignored: it sends no frame and changes no stored copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to load a DAC |
| addr_i | input | 4 | DAC address of the request |
| value_i | input | 8 | Code to load |
| rb_addr_i | input | 4 | Address of the stored copy to read |
| rb_data_o | output | 8 | Stored copy for rb_addr_i |
| busy_o | output | 1 | Sweep or transfer in progress |
| sclk_o | output | 1 | Shared serial clock |
| sdata_o | output | 1 | Shared serial data |
| load_o | output | 1 | Load strobe that commits the shifted code |
| eeprom_cs_o | output | 1 | Chip select of the shared serial memory, held inactive |
| eeprom_wp_o | output | 1 | Write-protect release of the shared serial memory, held inactive |

## Verification
The assertions assume that `start_i` is a clean synchronous pulse whose `addr_i` and `value_i` are stable in the cycle the pulse is sampled. They also assume that reset is applied long enough for the stored copies to settle before the first request. The stimulus changes every input only on falling clock edges and holds each start high for one cycle. Some starts are placed deliberately while busy is high or with an unchanged code, so that the ignored paths are exercised inside those assumptions. Every address used is inside the bank.

// File: rtl/caldac_pkg.sv
package caldac_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_LATCH = 2'd2
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/caldac_phase_timer.sv
module caldac_phase_timer #(
   parameter int unsigned HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CNT_W = caldac_pkg::cnt_width(HALF_CYC);

   initial assert (HALF_CYC >= 1) else $fatal(1, "HALF_CYC must be at least 1");

   generate
      if (HALF_CYC == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == LAST);

         // R2
         cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate
endmodule

// File: rtl/caldac_shadow.sv
module caldac_shadow #(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_CH    = 16,
   parameter logic [DATA_W-1:0] INIT_CODE = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] cmp_addr,
   output logic [DATA_W-1:0] cmp_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned SLOTS = 1 << ADDR_W;

   initial assert (NUM_CH >= 1 && NUM_CH <= SLOTS)
      else $fatal(1, "NUM_CH does not fit the address width");

   logic [DATA_W-1:0] copy_q [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         if (s < NUM_CH) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  copy_q[s] <= INIT_CODE;
               end else if (wr_en && (wr_addr == ADDR_W'(s))) begin
                  copy_q[s] <= wr_data;
               end
            end
         end else begin : g_unused
            assign copy_q[s] = '0;
         end
      end
   endgenerate

   assign cmp_data = copy_q[cmp_addr];
   assign rd_data  = copy_q[rd_addr];

   // R7
   copy_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (copy_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/caldac_shifter.sv
module caldac_shifter #(
   parameter int unsigned FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic               tick,
   output logic               sclk,
   output logic               sdata,
   output logic               done,
   output logic               active
);
   localparam int unsigned BC_W = caldac_pkg::cnt_width(FRAME_W + 1);

   logic [FRAME_W-1:0] shreg_q;
   logic [BC_W-1:0]    left_q;
   logic               sclk_q;
   logic               active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         left_q   <= '0;
         sclk_q   <= 1'b0;
         active_q <= 1'b0;
      end else if (load && !active_q) begin
         shreg_q  <= frame;
         left_q   <= BC_W'(FRAME_W);
         sclk_q   <= 1'b0;
         active_q <= 1'b1;
      end else if (active_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q  <= 1'b0;
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
            if (left_q == BC_W'(1)) begin
               active_q <= 1'b0;
            end
         end
      end
   end

   assign sclk   = sclk_q;
   assign sdata  = shreg_q[FRAME_W-1];
   assign active = active_q;
   assign done   = active_q && tick && sclk_q && (left_q == BC_W'(1));

   // R2
   data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_q && $past(sclk_q)) |-> $stable(shreg_q[FRAME_W-1]));

   // R1
   bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= BC_W'(FRAME_W));

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> !sclk_q);
endmodule

// File: rtl/caldac_loader.sv
module caldac_loader #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_CH   = 16,
   parameter int unsigned HALF_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] value_i,
   input  logic [ADDR_W-1:0] rb_addr_i,
   output logic [DATA_W-1:0] rb_data_o,
   output logic              busy_o,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              load_o,
   output logic              eeprom_cs_o,
   output logic              eeprom_wp_o
);
   import caldac_pkg::*;

   localparam int unsigned FRAME_W = ADDR_W + DATA_W;
   localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [ADDR_W:0]   CH_LIM   = (ADDR_W+1)'(NUM_CH);
   localparam logic [ADDR_W-1:0] LAST_CH  = ADDR_W'(NUM_CH - 1);

   initial assert (ADDR_W >= 1 && DATA_W >= 2)
      else $fatal(1, "field widths too small");

   seq_state_t        state_q;
   logic              load_q;
   logic              sweep_q;
   logic [ADDR_W-1:0] sweep_ch_q;

   logic              tick;
   logic              run;
   logic              shift_done;
   logic              shift_active;
   logic [DATA_W-1:0] cmp_data;
   logic              addr_ok;
   logic              accept;
   logic              sweep_issue;
   logic              issue;
   logic [FRAME_W-1:0] frame;

   assign addr_ok     = ({1'b0, addr_i} < CH_LIM);
   assign accept      = (state_q == SEQ_IDLE) && !sweep_q && start_i &&
                        addr_ok && (cmp_data != value_i);
   assign sweep_issue = (state_q == SEQ_IDLE) && sweep_q;
   assign issue       = accept || sweep_issue;
   assign frame       = sweep_issue ? {sweep_ch_q, MID_CODE} : {addr_i, value_i};
   assign run         = (state_q != SEQ_IDLE);

   caldac_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   caldac_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (issue),
      .frame  (frame),
      .tick   (tick && (state_q == SEQ_SHIFT)),
      .sclk   (sclk_o),
      .sdata  (sdata_o),
      .done   (shift_done),
      .active (shift_active)
   );

   caldac_shadow #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_CH    (NUM_CH),
      .INIT_CODE (MID_CODE)
   ) u_copy (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept),
      .wr_addr  (addr_i),
      .wr_data  (value_i),
      .cmp_addr (addr_i),
      .cmp_data (cmp_data),
      .rd_addr  (rb_addr_i),
      .rd_data  (rb_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         load_q     <= 1'b0;
         sweep_q    <= 1'b1;
         sweep_ch_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (issue) begin
                  state_q <= SEQ_SHIFT;
               end
            end
            SEQ_SHIFT: begin
               if (shift_done) begin
                  state_q <= SEQ_LATCH;
                  load_q  <= 1'b1;
               end
            end
            SEQ_LATCH: begin
               if (tick) begin
                  state_q <= SEQ_IDLE;
                  load_q  <= 1'b0;
                  if (sweep_q) begin
                     if (sweep_ch_q == LAST_CH) begin
                        sweep_q <= 1'b0;
                     end else begin
                        sweep_ch_q <= sweep_ch_q + 1'b1;
                     end
                  end
               end
            end
            default: begin
               state_q <= SEQ_IDLE;
               load_q  <= 1'b0;
            end
         endcase
      end
   end

   assign busy_o      = sweep_q || (state_q != SEQ_IDLE);
   assign load_o      = load_q;
   assign eeprom_cs_o = 1'b0;
   assign eeprom_wp_o = 1'b0;

   // R3
   load_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> !sclk_o);

   // R3
   load_not_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |-> !shift_active);

   // R8
   sclk_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> busy_o);

   // R8
   busy_fall_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $fell(load_o));

   // R5
   same_code_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && addr_ok && (rb_data_o == value_i) && (rb_addr_i == addr_i))
      |=> (!busy_o && !load_o));

   // R8
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |-> !accept);
endmodule

// File: tb/caldac_loader_bench.sv
module caldac_loader_bench;
   localparam int unsigned HALF = 2;
   localparam int unsigned NCH  = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] addr_i = '0;
   logic [7:0] value_i = '0;
   logic [3:0] rb_addr_i = '0;
   logic [7:0] rb_data_o;
   logic       busy_o, sclk_o, sdata_o, load_o, eeprom_cs_o, eeprom_wp_o;

   always #2 clk = ~clk;

   caldac_loader #(.ADDR_W(4), .DATA_W(8), .NUM_CH(NCH), .HALF_CYC(HALF)) u_caldac_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .value_i(value_i),
      .rb_addr_i(rb_addr_i), .rb_data_o(rb_data_o), .busy_o(busy_o), .sclk_o(sclk_o),
      .sdata_o(sdata_o), .load_o(load_o), .eeprom_cs_o(eeprom_cs_o), .eeprom_wp_o(eeprom_wp_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   // serial monitor
   logic        p_sclk = 0, p_sdata = 0, p_load = 0, p_busy = 0;
   logic [11:0] sh = '0;
   int          bitcnt = 0, frames = 0, lw = 0, hw = 0, lowc = 0;
   logic [11:0] last_frame = '0;
   logic [11:0] init_log [NCH];
   int v_bits = 0, v_data_hi = 0, v_load_sclk = 0, v_lwidth = 0, v_busyfall = 0;
   int v_sides = 0, v_hwidth = 0, v_lowidth = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (eeprom_cs_o || eeprom_wp_o) v_sides++;
         if (sclk_o && !p_sclk) begin
            sh = {sh[10:0], sdata_o};
            bitcnt++;
            if (lowc < HALF) v_lowidth++;
            hw = 0;
         end
         if (sclk_o) hw++;
         if (!sclk_o && p_sclk && hw != HALF) v_hwidth++;
         if (sclk_o) lowc = 0; else lowc++;
         if (sclk_o && p_sclk && sdata_o != p_sdata) v_data_hi++;
         if (load_o && sclk_o) v_load_sclk++;
         if (load_o) lw++;
         if (load_o && !p_load) begin
            if (bitcnt != 12) v_bits++;
            last_frame = sh;
            if (frames < NCH) init_log[frames] = sh;
            frames++;
            bitcnt = 0;
         end
         if (!load_o && p_load) begin
            if (lw != HALF) v_lwidth++;
            lw = 0;
         end
         if (p_busy && !busy_o && !(p_load && !load_o)) v_busyfall++;
      end
      p_sclk = sclk_o; p_sdata = sdata_o; p_load = load_o; p_busy = busy_o;
   end

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
   endtask

   task automatic read_copy(input logic [3:0] a, output logic [7:0] d);
      rb_addr_i = a;
      #1 d = rb_data_o;
   endtask

   task automatic pulse_start(input logic [3:0] a, input logic [7:0] v);
      addr_i = a; value_i = v; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // {addr[3:0], code[7:0], frame_expected}
   localparam logic [12:0] VEC [8] = '{
      {4'd3,  8'h80, 1'b0},
      {4'd3,  8'h5A, 1'b1},
      {4'd3,  8'h5A, 1'b0},
      {4'd0,  8'hFF, 1'b1},
      {4'd15, 8'h00, 1'b1},
      {4'd15, 8'h01, 1'b1},
      {4'd9,  8'hA5, 1'b1},
      {4'd0,  8'hFF, 1'b0}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      int f0;
      repeat (3) @(negedge clk);
      // reset state (R4, R6)
      chk(busy_o == 1'b1, "R6 busy in reset", busy_o, 1);
      chk(sclk_o == 1'b0 && load_o == 1'b0, "R3 lines low in reset", {sclk_o, load_o}, 0);
      chk(eeprom_cs_o == 1'b0 && eeprom_wp_o == 1'b0, "R4 memory lines in reset",
          {eeprom_cs_o, eeprom_wp_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 1'b1, "R6 busy at sweep start", busy_o, 1);
      // start during sweep must be ignored (R8)
      pulse_start(4'd7, 8'h12);
      wait_idle();
      chk(frames == NCH, "R6 sweep frame count", frames, NCH);
      for (int i = 0; i < NCH; i++)
         chk(init_log[i] == {i[3:0], 8'h80}, "R6 R1 sweep frame", init_log[i], {i[3:0], 8'h80});
      for (int i = 0; i < NCH; i++) begin
         read_copy(i[3:0], d);
         chk(d == 8'h80, "R7 copy after reset", d, 8'h80);
      end

      // vector walk
      foreach (VEC[k]) begin
         f0 = frames;
         pulse_start(VEC[k][12:9], VEC[k][8:1]);
         chk(busy_o == VEC[k][0], "R8 R5 busy after start", busy_o, VEC[k][0]);
         wait_idle();
         @(negedge clk);
         chk(frames - f0 == int'(VEC[k][0]), "R5 frame count", frames - f0, VEC[k][0]);
         if (VEC[k][0])
            chk(last_frame == VEC[k][12:1], "R1 frame content", last_frame, VEC[k][12:1]);
         read_copy(VEC[k][12:9], d);
         chk(d == VEC[k][8:1], "R7 copy", d, VEC[k][8:1]);
      end

      // start while busy ignored (R8)
      f0 = frames;
      pulse_start(4'd2, 8'h33);
      chk(busy_o == 1'b1, "R8 busy rises", busy_o, 1);
      repeat (3) @(negedge clk);
      pulse_start(4'd4, 8'h11);
      wait_idle();
      @(negedge clk);
      chk(frames - f0 == 1, "R8 one frame only", frames - f0, 1);
      chk(last_frame == {4'd2, 8'h33}, "R1 frame after busy start", last_frame, {4'd2, 8'h33});
      read_copy(4'd4, d);
      chk(d == 8'h80, "R8 ignored start left copy", d, 8'h80);
      read_copy(4'd2, d);
      chk(d == 8'h33, "R7 copy of accepted", d, 8'h33);

      // unchanged code after a change: skipped, busy low (R5)
      f0 = frames;
      pulse_start(4'd2, 8'h33);
      chk(busy_o == 1'b0, "R5 busy stays low", busy_o, 0);
      repeat (10) @(negedge clk);
      chk(frames == f0, "R5 no frame", frames - f0, 0);

      // protocol monitors
      chk(v_bits == 0, "R1 bits per frame", v_bits, 0);
      chk(v_data_hi == 0, "R2 data steady while sclk high", v_data_hi, 0);
      chk(v_hwidth == 0, "R2 sclk high width", v_hwidth, 0);
      chk(v_lowidth == 0, "R2 sclk low width", v_lowidth, 0);
      chk(v_load_sclk == 0, "R3 load with sclk low", v_load_sclk, 0);
      chk(v_lwidth == 0, "R3 load width", v_lwidth, 0);
      chk(v_busyfall == 0, "R8 busy falls with load", v_busyfall, 0);
      chk(v_sides == 0, "R4 memory lines inactive", v_sides, 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule